// File: doc/BRIEF.md
# Exponent-Coded Clock Divider Bank

This block holds the divide settings for six clock domains: core, peripheral, DSP, DSP-MMU, traffic controller and LCD. All six live in one 16-bit control word, as 2-bit exponents. A domain's divisor is 2 to the power of its exponent, so it is 1, 2, 4 or 8. From a shared parent rate the bank derives each domain's rate. It also produces a per-domain clock-enable strobe, which is qualified by a per-domain gate input.

There are two ways to change the word. A rate request names one domain and a target rate. The bank picks the smallest exponent whose divided rate does not exceed the target and places it in that domain's field. A raw write supplies a whole new word. Either way, the pending word passes through a fixed-order legaliser before it is committed. The legaliser enforces the ratios the domains must keep to one another. Four upper bits carry no divider meaning and are stored exactly as written.

A rate request that cannot be met is refused. This happens when the target is below the parent rate divided by 8, or when the domain code is unknown. A refused request raises a one-cycle error and leaves the word untouched.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset the control word equals the reset value (default 0x0000, all divisors 1), the error output is low, and every derived rate equals the parent rate.
- R2: A rate request for domain code D (0 core, 1 peripheral, 2 DSP, 3 DSP-MMU, 4 traffic controller, 5 LCD) writes into bits [2D+1:2D] the first exponent e in 0,1,2,3 for which parent>>e is not above the target. The legalised word is visible one cycle after the request.
- R3: A rate request whose target is below parent>>3, or whose domain code is 6 or 7, is refused. The error output is high for the cycle after the request and the control word is unchanged.
- R4: The committed DSP-MMU exponent is raised to at least the DSP exponent and then limited to at most the DSP exponent plus 1.
- R5: The committed traffic-controller exponent is raised to at least the core exponent, and then to at least the clamped DSP-MMU exponent.
- R6: After R5, a peripheral or LCD exponent that is below the traffic-controller exponent is raised to equal it.
- R7: Bits [15:12] of the control word take the value of a raw write. A rate request leaves them unchanged.
- R8: Each domain's derived rate equals parent>>exponent, and updates one cycle after the control word or the parent rate changes.
- R9: A domain's rate-update strobe is high for one cycle exactly when its derived rate changes. A commit that leaves a rate unchanged gives no strobe.
- R10: A domain's clock enable is low while its gate input is low. While the gate is high, the enable is high once every 2^exponent cycles, which gives 16>>exponent strobes in any 16 consecutive cycles.
- R11: When a raw write and a rate request fall in the same cycle, the requested field replaces that field of the raw data before legalising. If the rate request is refused, neither is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_req | input | 1 | Rate request strobe |
| rate_dom | input | 3 | Domain code of the rate request |
| rate_target | input | RW | Target rate for the rate request |
| raw_wr | input | 1 | Raw whole-word write strobe |
| raw_data | input | 16 | Raw control word |
| parent_rate | input | RW | Shared parent rate |
| gate_en | input | 6 | Per-domain gate, bit D for domain D |
| ctrl_word | output | 16 | Committed control word |
| req_err | output | 1 | One-cycle refusal flag |
| dom_rate | output | 6*RW | Derived rates, domain D at bits [RW*D+RW-1:RW*D] |
| rate_upd | output | 6 | Per-domain rate-change strobe |
| clk_en | output | 6 | Per-domain clock enable |

## Verification
A raw write and a rate request can land in the same cycle. The bench provokes this once with a target the bank can meet, and once with a target it must refuse. It judges the committed word against a model: the raw data, with the requested field substituted, then legalised. For the refused case it expects the previous word and a raised error. The rate strobes that follow are compared domain by domain against the derived rates the model predicts.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int NDOM  = 6;
  localparam int EXPW  = 2;
  localparam int REGW  = 16;
  localparam int CNTW  = 3;
  localparam int SPARE_LO = NDOM * EXPW;

  typedef enum logic [2:0] {
    DOM_CORE = 3'd0,
    DOM_PER  = 3'd1,
    DOM_DSP  = 3'd2,
    DOM_MMU  = 3'd3,
    DOM_TC   = 3'd4,
    DOM_LCD  = 3'd5
  } dom_e;
endpackage

// File: rtl/clkdiv_expsel.sv
module clkdiv_expsel
  import clkdiv_pkg::*;
#(
  parameter int RW = 32
) (
  input  logic [RW-1:0]   parent_i,
  input  logic [RW-1:0]   target_i,
  output logic [EXPW-1:0] exp_o,
  output logic            ok_o
);
  localparam int NEXP = 1 << EXPW;

  always_comb begin
    exp_o = '0;
    ok_o  = 1'b0;
    for (int e = NEXP - 1; e >= 0; e--) begin
      if ((parent_i >> e) <= target_i) begin
        exp_o = EXPW'(e);
        ok_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkdiv_legalise.sv
module clkdiv_legalise
  import clkdiv_pkg::*;
(
  input  logic [REGW-1:0] word_i,
  output logic [REGW-1:0] word_o
);
  logic [EXPW:0] e_core, e_per, e_dsp, e_mmu, e_tc, e_lcd;

  always_comb begin
    e_core = {1'b0, word_i[EXPW*DOM_CORE +: EXPW]};
    e_per  = {1'b0, word_i[EXPW*DOM_PER  +: EXPW]};
    e_dsp  = {1'b0, word_i[EXPW*DOM_DSP  +: EXPW]};
    e_mmu  = {1'b0, word_i[EXPW*DOM_MMU  +: EXPW]};
    e_tc   = {1'b0, word_i[EXPW*DOM_TC   +: EXPW]};
    e_lcd  = {1'b0, word_i[EXPW*DOM_LCD  +: EXPW]};
    // fixed order: MMU window, TC floors, then followers
    if (e_mmu < e_dsp)         e_mmu = e_dsp;
    if (e_mmu > e_dsp + 3'd1)  e_mmu = e_dsp + 3'd1;
    if (e_tc < e_core)         e_tc  = e_core;
    if (e_tc < e_mmu)          e_tc  = e_mmu;
    if (e_tc > e_lcd)          e_lcd = e_tc;
    if (e_tc > e_per)          e_per = e_tc;
    word_o = word_i;
    word_o[EXPW*DOM_CORE +: EXPW] = e_core[EXPW-1:0];
    word_o[EXPW*DOM_PER  +: EXPW] = e_per[EXPW-1:0];
    word_o[EXPW*DOM_DSP  +: EXPW] = e_dsp[EXPW-1:0];
    word_o[EXPW*DOM_MMU  +: EXPW] = e_mmu[EXPW-1:0];
    word_o[EXPW*DOM_TC   +: EXPW] = e_tc[EXPW-1:0];
    word_o[EXPW*DOM_LCD  +: EXPW] = e_lcd[EXPW-1:0];
  end
endmodule

// File: rtl/clkdiv_domain.sv
module clkdiv_domain
  import clkdiv_pkg::*;
#(
  parameter int RW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RW-1:0]   parent_i,
  input  logic [EXPW-1:0] exp_i,
  input  logic            gate_i,
  input  logic [CNTW-1:0] tick_i,
  output logic [RW-1:0]   rate_o,
  output logic            upd_o,
  output logic            en_o
);
  logic [RW-1:0]   rate_d;
  logic            upd_d;
  logic [CNTW-1:0] mask;

  always_comb begin
    rate_d = parent_i >> exp_i;
    upd_d  = (rate_d != rate_o);
    mask   = (CNTW'(1) << exp_i) - CNTW'(1);
    en_o   = gate_i && ((tick_i & mask) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      rate_o <= rate_d;
      upd_o  <= upd_d;
    end
  end

  // R9
  upd_changes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (rate_o != $past(rate_o)));

  // R10
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_i |-> !en_o);
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int              RW        = 32,
  parameter logic [REGW-1:0] RESET_VAL = 16'h0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rate_req,
  input  logic [2:0]         rate_dom,
  input  logic [RW-1:0]      rate_target,
  input  logic               raw_wr,
  input  logic [REGW-1:0]    raw_data,
  input  logic [RW-1:0]      parent_rate,
  input  logic [NDOM-1:0]    gate_en,
  output logic [REGW-1:0]    ctrl_word,
  output logic               req_err,
  output logic [NDOM*RW-1:0] dom_rate,
  output logic [NDOM-1:0]    rate_upd,
  output logic [NDOM-1:0]    clk_en
);
  logic [1:0]      rst_sync;
  logic            rst_ni;
  logic [REGW-1:0] ctrl_q, ctrl_d, base, merged, legal;
  logic            err_d, sel_ok, dom_ok, refuse;
  logic [EXPW-1:0] sel_exp;
  logic [CNTW-1:0] tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  clkdiv_expsel #(.RW(RW)) u_sel (
    .parent_i (parent_rate),
    .target_i (rate_target),
    .exp_o    (sel_exp),
    .ok_o     (sel_ok)
  );

  clkdiv_legalise u_leg (
    .word_i (merged),
    .word_o (legal)
  );

  always_comb begin
    dom_ok = (rate_dom < 3'(NDOM));
    refuse = rate_req && !(sel_ok && dom_ok);
    base   = raw_wr ? raw_data : ctrl_q;
    merged = base;
    if (rate_req) begin
      for (int i = 0; i < NDOM; i++) begin
        if (rate_dom == 3'(i)) merged[EXPW*i +: EXPW] = sel_exp;
      end
    end
    if (refuse)                  ctrl_d = ctrl_q;
    else if (rate_req || raw_wr) ctrl_d = legal;
    else                         ctrl_d = ctrl_q;
    err_d = refuse;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= RESET_VAL;
      req_err <= 1'b0;
      tick_q  <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      req_err <= err_d;
      tick_q  <= tick_q + CNTW'(1);
    end
  end

  assign ctrl_word = ctrl_q;

  genvar g;
  generate
    for (g = 0; g < NDOM; g++) begin : g_dom
      clkdiv_domain #(.RW(RW)) u_dom (
        .clk      (clk),
        .rst_n    (rst_ni),
        .parent_i (parent_rate),
        .exp_i    (ctrl_q[EXPW*g +: EXPW]),
        .gate_i   (gate_en[g]),
        .tick_i   (tick_q),
        .rate_o   (dom_rate[RW*g +: RW]),
        .upd_o    (rate_upd[g]),
        .en_o     (clk_en[g])
      );
    end
  endgenerate

  // R3
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    req_err |-> (ctrl_q == $past(ctrl_q)));

  // R3
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    req_err |-> $past(rate_req));

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!rate_req && !raw_wr) |=> $stable(ctrl_q));

  // R4
  mmu_window_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q[EXPW*DOM_MMU +: EXPW] >= ctrl_q[EXPW*DOM_DSP +: EXPW]) &&
    ({1'b0, ctrl_q[EXPW*DOM_MMU +: EXPW]} <= {1'b0, ctrl_q[EXPW*DOM_DSP +: EXPW]} + 3'd1));

  // R5
  tc_floor_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q[EXPW*DOM_TC +: EXPW] >= ctrl_q[EXPW*DOM_CORE +: EXPW]) &&
    (ctrl_q[EXPW*DOM_TC +: EXPW] >= ctrl_q[EXPW*DOM_MMU +: EXPW]));

  // R6
  follower_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q[EXPW*DOM_PER +: EXPW] >= ctrl_q[EXPW*DOM_TC +: EXPW]) &&
    (ctrl_q[EXPW*DOM_LCD +: EXPW] >= ctrl_q[EXPW*DOM_TC +: EXPW]));

  // R7
  spare_keep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!raw_wr) |=> $stable(ctrl_q[REGW-1:SPARE_LO]));
endmodule

// File: tb/clkdiv_bank_tb.sv
`timescale 1ns/100ps
module clkdiv_bank_tb;
  localparam int RW = 32;
  localparam int ND = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rate_req = 1'b0;
  logic [2:0]    rate_dom = '0;
  logic [RW-1:0] rate_target = '0;
  logic          raw_wr = 1'b0;
  logic [15:0]   raw_data = '0;
  logic [RW-1:0] parent_rate = 32'd800;
  logic [ND-1:0] gate_en = '0;
  logic [15:0]   ctrl_word;
  logic          req_err;
  logic [ND*RW-1:0] dom_rate;
  logic [ND-1:0] rate_upd;
  logic [ND-1:0] clk_en;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [15:0] ctrl;
    logic        err;
    string       tag;
  } sb_item_t;
  sb_item_t sb[$];

  logic [15:0]   model_ctrl = 16'h0000;
  logic [RW-1:0] last_rate [ND];

  always #2.5 clk = ~clk;

  clkdiv_bank #(.RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rate_req(rate_req), .rate_dom(rate_dom),
    .rate_target(rate_target), .raw_wr(raw_wr), .raw_data(raw_data),
    .parent_rate(parent_rate), .gate_en(gate_en), .ctrl_word(ctrl_word),
    .req_err(req_err), .dom_rate(dom_rate), .rate_upd(rate_upd), .clk_en(clk_en)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] legal_m(input logic [15:0] v);
    int c, p, d, m, t, l;
    logic [15:0] r;
    c = int'(v[1:0]); p = int'(v[3:2]); d = int'(v[5:4]);
    m = int'(v[7:6]); t = int'(v[9:8]); l = int'(v[11:10]);
    if (m < d) m = d;
    if (m > d + 1) m = d + 1;
    if (t < c) t = c;
    if (t < m) t = m;
    if (l < t) l = t;
    if (p < t) p = t;
    r = v;
    r[1:0] = 2'(c); r[3:2] = 2'(p); r[5:4] = 2'(d);
    r[7:6] = 2'(m); r[9:8] = 2'(t); r[11:10] = 2'(l);
    return r;
  endfunction

  function automatic int pick_exp(input logic [RW-1:0] par, input logic [RW-1:0] tgt);
    for (int e = 0; e < 4; e++) if ((par >> e) <= tgt) return e;
    return 4;
  endfunction

  // driver: one request cycle, expected result pushed to the scoreboard
  task automatic drive(input bit do_rate, input int dom, input logic [RW-1:0] tgt,
                       input bit do_raw, input logic [15:0] raw, input string tag);
    sb_item_t it;
    logic [15:0] b;
    int e;
    bit refused;
    e = pick_exp(parent_rate, tgt);
    refused = do_rate && (dom > 5 || e == 4);
    b = do_raw ? raw : model_ctrl;
    if (do_rate && !refused) b[2*dom +: 2] = 2'(e);
    if (!refused && (do_rate || do_raw)) model_ctrl = legal_m(b);
    it.ctrl = model_ctrl; it.err = refused; it.tag = tag;
    @(negedge clk);
    rate_req = do_rate; rate_dom = 3'(dom); rate_target = tgt;
    raw_wr = do_raw; raw_data = raw;
    sb.push_back(it);
    @(negedge clk);
    rate_req = 1'b0; raw_wr = 1'b0;
  endtask

  // monitor: compares the cycle after each request
  initial begin
    forever begin
      bit fire;
      sb_item_t it;
      @(posedge clk);
      fire = rate_req | raw_wr;
      #1;
      if (fire) begin
        if (sb.size() == 0) begin
          check(0, "scoreboard empty R2", 0, 1);
        end else begin
          it = sb.pop_front();
          check(ctrl_word == it.ctrl, {it.tag, " ctrl"}, 64'(ctrl_word), 64'(it.ctrl));
          check(req_err == it.err, {it.tag, " err"}, 64'(req_err), 64'(it.err));
        end
      end
    end
  end

  // rates one edge after the commit (R8, R9)
  task automatic check_rates(input string tag);
    @(posedge clk); #1;
    for (int i = 0; i < ND; i++) begin
      logic [RW-1:0] er;
      logic eu;
      er = parent_rate >> model_ctrl[2*i +: 2];
      eu = (er != last_rate[i]);
      check(dom_rate[RW*i +: RW] == er, {tag, " R8 rate"}, 64'(dom_rate[RW*i +: RW]), 64'(er));
      check(rate_upd[i] == eu, {tag, " R9 upd"}, 64'(rate_upd[i]), 64'(eu));
      last_rate[i] = er;
    end
  endtask

  task automatic count_en(input string tag);
    int cnt [ND];
    for (int i = 0; i < ND; i++) cnt[i] = 0;
    for (int k = 0; k < 16; k++) begin
      @(posedge clk); #1;
      for (int i = 0; i < ND; i++) if (clk_en[i]) cnt[i]++;
    end
    for (int i = 0; i < ND; i++) begin
      int ex;
      ex = gate_en[i] ? (16 >> model_ctrl[2*i +: 2]) : 0;
      check(cnt[i] == ex, {tag, " R10 enables"}, 64'(cnt[i]), 64'(ex));
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    // R1 reset state
    check(ctrl_word == 16'h0000, "R1 reset ctrl", 64'(ctrl_word), 0);
    check(req_err == 1'b0, "R1 reset err", 64'(req_err), 0);
    for (int i = 0; i < ND; i++) begin
      check(dom_rate[RW*i +: RW] == parent_rate, "R1 reset rate",
            64'(dom_rate[RW*i +: RW]), 64'(parent_rate));
      last_rate[i] = parent_rate;
    end

    // R2 core to 400 -> exp 1, R5/R6 pull tc, per, lcd
    drive(1, 0, 32'd400, 0, 16'h0, "R2 R5 R6 core");
    check_rates("core");
    // R2 between rates: 500 -> exp 1 on peripheral
    drive(1, 1, 32'd500, 0, 16'h0, "R2 per");
    check_rates("per");
    // R4 dsp to 100 -> exp 3, mmu forced to 3
    drive(1, 2, 32'd100, 0, 16'h0, "R4 dsp");
    check_rates("dsp");
    // R3 target below parent/8
    drive(1, 3, 32'd99, 0, 16'h0, "R3 low target");
    check_rates("refuse");
    // R3 invalid domain code
    drive(1, 7, 32'd800, 0, 16'h0, "R3 bad domain");
    check_rates("refuse2");
    // R7 raw write: spare bits kept, dsp=2 pulls mmu/tc/per/lcd
    drive(0, 0, 0, 1, 16'hA020, "R7 R4 raw");
    check_rates("raw");
    check(ctrl_word[15:12] == 4'hA, "R7 spare", 64'(ctrl_word[15:12]), 64'hA);
    // R6 lcd request for exp 0 is raised back, spare bits untouched
    drive(1, 5, 32'd800, 0, 16'h0, "R6 R7 lcd");
    check_rates("lcd");
    // R4 mmu above dsp+1 is limited
    drive(0, 0, 0, 1, 16'h50C0, "R4 mmu limit");
    check_rates("mmu");
    // R9 same word again: no strobes
    drive(0, 0, 0, 1, 16'h50C0, "R9 same");
    check_rates("same");
    // R11 coincident raw + accepted rate
    drive(1, 0, 32'd200, 1, 16'h3000, "R11 merge");
    check_rates("merge");
    // R11 coincident raw + refused rate
    drive(1, 2, 32'd10, 1, 16'hF000, "R11 refused merge");
    check_rates("refmerge");
    // R10 enables with a gate pattern
    drive(0, 0, 0, 1, 16'h0AA4, "R10 setup");
    check_rates("en");
    gate_en = 6'b101101;
    count_en("gated");
    // R8 parent change updates all domains
    @(negedge clk);
    parent_rate = 32'd1600;
    check_rates("parent");
    check_rates("parent steady");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule